// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block sits between a processor load/store port and a slower memory that moves whole lines. The processor presents one word access at a time: an address, a read/write flag, write data and byte enables. It holds the request until the cache raises a one-cycle ready pulse. Loads return their word alongside that pulse. The memory side carries one whole-line transfer at a time. Each transfer is either a line write of an evicted modified line or a line read for a refill. A request/acknowledge pair closes each transfer.

The address is split three ways. The upper bits form the tag. The next bits select the set, which is the line number modulo the number of sets. The low bits locate the word inside the line. Each set has two ways, and each way has its own valid, dirty and tag storage. One bit per set marks the least recently used way. Loads read the tags and the data in the same cycle and keep the data only on a hit. Stores check the tag in one cycle and write the data array in the next. A miss evicts the least recently used way. The evicted line is written to memory only if it is dirty. The missing line is then read in, and the access is checked again; for a store, this is what makes it write-allocate.

The controller has five states:
- IDLE: accepts a request and moves to COMPARE.
- COMPARE: on a hit it goes to RESPOND. On a miss it goes to WRITEBACK if the victim is dirty, otherwise to REFILL.
- WRITEBACK: moves to REFILL on acknowledge.
- REFILL: returns to COMPARE on acknowledge.
- RESPOND: pulses ready, commits any store, and returns to IDLE.

Top module: `dcache2w`

## Requirements
- R1: After reset every line is invalid and the ready and memory request outputs are low, so the first access to any address misses and reads its line from memory.
- R2: The set is taken from address bits just above the line offset (line number modulo SETS). A refill reads the memory line number equal to the address shifted right by log2(LINE_BYTES). Lines in different sets never evict each other.
- R3: A load that hits raises ready exactly 2 clock cycles after the cycle in which the request was accepted, with the addressed word on the read data output and no memory request.
- R4: A load that misses on a clean or invalid victim issues exactly one line read (write flag low). Ready follows 3 + L cycles after acceptance, where L is the memory acknowledge latency, and the returned word comes from the refilled line.
- R5: A store that hits replaces only the bytes whose enable bit is set (enable bit b covers data bits 8b+7..8b) and causes no memory transfer. Later loads see the merged word.
- R6: A store that misses first refills the line and then merges the store bytes into it (write-allocate). Ready comes with the same latency as a load miss.
- R7: On a miss the victim is the way of that set that was not used by the most recent hit or refill in that set.
- R8: A dirty victim is written to memory at its old line address (stored tag and set) with its full contents before the refill read. A clean victim is never written. Data written back is returned by a later refill of that line.
- R9: Ready stays low while a memory request is outstanding. The memory address and write flag stay stable until acknowledge.
- R10: The word inside a line is selected by the address bits between the byte offset and the line offset. The lowest log2(WORD_BYTES) address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8*WORD_BYTES | Store data |
| cpu_be | input | WORD_BYTES | Store byte enables |
| cpu_rdata | output | 8*WORD_BYTES | Load data, valid with ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | ADDR_W-log2(LINE_BYTES) | Line number |
| mem_wdata | output | 8*LINE_BYTES | Line being written back |
| mem_rdata | input | 8*LINE_BYTES | Refill line, valid with acknowledge |
| mem_ack | input | 1 | Memory transfer done |

## Verification
Every result has a fixed latency counted from the cycle in which a request is accepted. A hit completes in 2 cycles. A miss on a clean victim completes in 3 + L cycles, and a miss on a dirty victim in 3 + 2L cycles, where L is the responder's acknowledge latency. The reference model derives the expected latency for each access from its own view of tags, dirty bits and LRU. It then compares the ready output on every clock edge against that expected cycle, so an early, late or repeated pulse fails in the cycle it appears. Each memory transfer is checked when it is acknowledged, against a queue of the write-backs and refills the model predicted. Load data is compared in the single cycle where ready is high.

// File: rtl/dcache2w_pkg.sv
package dcache2w_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COMPARE,
        ST_WRITEBACK,
        ST_REFILL,
        ST_RESPOND
    } dc_state_t;

    localparam int NUM_WAYS = 2;

endpackage

// File: rtl/dcache2w_tags.sv
module dcache2w_tags #(
    parameter int SETS  = 512,
    parameter int IDX_W = $clog2(SETS),
    parameter int TAG_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    output logic [1:0]       hit_vec,
    output logic             vic_way,
    output logic             vic_dirty,
    output logic [TAG_W-1:0] vic_tag,
    input  logic             touch_en,
    input  logic             touch_way,
    input  logic             fill_en,
    input  logic             dirty_en,
    input  logic             dirty_way
);
    import dcache2w_pkg::*;

    logic [SETS-1:0]  lru_q;
    logic [TAG_W-1:0] tag_rd [NUM_WAYS];
    logic [1:0]       valid_rd;
    logic [1:0]       dirty_rd;

    generate
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
            logic [TAG_W-1:0] tag_mem [SETS];
            logic [SETS-1:0]  valid_q;
            logic [SETS-1:0]  dirty_q;

            always_ff @(posedge clk) begin
                if (fill_en && vic_way == 1'(w))
                    tag_mem[idx] <= tag;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    valid_q <= '0;
                    dirty_q <= '0;
                end else if (fill_en && vic_way == 1'(w)) begin
                    valid_q[idx] <= 1'b1;
                    dirty_q[idx] <= 1'b0;
                end else if (dirty_en && dirty_way == 1'(w)) begin
                    dirty_q[idx] <= 1'b1;
                end
            end

            assign tag_rd[w]   = tag_mem[idx];
            assign valid_rd[w] = valid_q[idx];
            assign dirty_rd[w] = dirty_q[idx];
            assign hit_vec[w]  = valid_q[idx] && (tag_mem[idx] == tag);
        end
    endgenerate

    assign vic_way   = lru_q[idx];
    assign vic_dirty = valid_rd[vic_way] && dirty_rd[vic_way];
    assign vic_tag   = tag_rd[vic_way];

    // The per-set bit names the way to evict next: the one not just used.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lru_q <= '0;
        else if (fill_en)
            lru_q[idx] <= ~vic_way;
        else if (touch_en)
            lru_q[idx] <= ~touch_way;
    end

endmodule

// File: rtl/dcache2w_data.sv
module dcache2w_data #(
    parameter int SETS   = 512,
    parameter int IDX_W  = $clog2(SETS),
    parameter int LINE_W = 512,
    parameter int WORD_W = 32,
    parameter int WSEL_W = 4
) (
    input  logic                        clk,
    input  logic [IDX_W-1:0]            idx,
    output logic [1:0][LINE_W-1:0]      rd_lines,
    input  logic                        fill_en,
    input  logic                        fill_way,
    input  logic [LINE_W-1:0]           fill_line,
    input  logic                        st_en,
    input  logic                        st_way,
    input  logic [WSEL_W-1:0]           st_wsel,
    input  logic [WORD_W-1:0]           st_word,
    input  logic [WORD_W/8-1:0]         st_be
);
    import dcache2w_pkg::*;

    localparam int NBYTES = WORD_W / 8;

    generate
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
            logic [LINE_W-1:0] line_mem [SETS];
            logic [LINE_W-1:0] merged;

            always_comb begin
                merged = line_mem[idx];
                for (int b = 0; b < NBYTES; b++) begin
                    if (st_be[b])
                        merged[int'(st_wsel) * WORD_W + b * 8 +: 8] = st_word[b * 8 +: 8];
                end
            end

            always_ff @(posedge clk) begin
                if (fill_en && fill_way == 1'(w))
                    line_mem[idx] <= fill_line;
                else if (st_en && st_way == 1'(w))
                    line_mem[idx] <= merged;
            end

            assign rd_lines[w] = line_mem[idx];
        end
    endgenerate

endmodule

// File: rtl/dcache2w_ctrl.sv
module dcache2w_ctrl #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_req,
    input  logic                   cpu_we,
    input  logic [ADDR_W-1:0]      cpu_addr,
    input  logic [WORD_W-1:0]      cpu_wdata,
    input  logic [WORD_W/8-1:0]    cpu_be,
    input  logic                   any_hit,
    input  logic                   vic_dirty,
    input  logic                   mem_ack,
    output dcache2w_pkg::dc_state_t state,
    output logic [ADDR_W-1:0]      req_addr,
    output logic                   req_we,
    output logic [WORD_W-1:0]      req_wdata,
    output logic [WORD_W/8-1:0]    req_be,
    output logic                   touch_en,
    output logic                   rd_load,
    output logic                   st_en,
    output logic                   fill_en,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic                   cpu_ready
);
    import dcache2w_pkg::*;

    dc_state_t state_q, state_d;

    assign state = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            req_addr  <= '0;
            req_we    <= 1'b0;
            req_wdata <= '0;
            req_be    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cpu_req) begin
                req_addr  <= cpu_addr;
                req_we    <= cpu_we;
                req_wdata <= cpu_wdata;
                req_be    <= cpu_be;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (cpu_req) state_d = ST_COMPARE;
            ST_COMPARE: begin
                if (any_hit)        state_d = ST_RESPOND;
                else if (vic_dirty) state_d = ST_WRITEBACK;
                else                state_d = ST_REFILL;
            end
            ST_WRITEBACK: if (mem_ack) state_d = ST_REFILL;
            ST_REFILL:    if (mem_ack) state_d = ST_COMPARE;
            ST_RESPOND:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        touch_en  = 1'b0;
        rd_load   = 1'b0;
        st_en     = 1'b0;
        fill_en   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        cpu_ready = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_COMPARE: begin
                touch_en = any_hit;
                rd_load  = any_hit && !req_we;
            end
            ST_WRITEBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_REFILL: begin
                mem_req = 1'b1;
                fill_en = mem_ack;
            end
            ST_RESPOND: begin
                cpu_ready = 1'b1;
                st_en     = req_we;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dcache2w.sv
module dcache2w #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int SETS       = 512,
    parameter int WORD_BYTES = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cpu_req,
    input  logic                                  cpu_we,
    input  logic [ADDR_W-1:0]                     cpu_addr,
    input  logic [8*WORD_BYTES-1:0]               cpu_wdata,
    input  logic [WORD_BYTES-1:0]                 cpu_be,
    output logic [8*WORD_BYTES-1:0]               cpu_rdata,
    output logic                                  cpu_ready,
    output logic                                  mem_req,
    output logic                                  mem_we,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  mem_addr,
    output logic [8*LINE_BYTES-1:0]               mem_wdata,
    input  logic [8*LINE_BYTES-1:0]               mem_rdata,
    input  logic                                  mem_ack
);
    import dcache2w_pkg::*;

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int BYTE_W = $clog2(WORD_BYTES);
    localparam int WSEL_W = OFF_W - BYTE_W;
    localparam int LINE_W = 8 * LINE_BYTES;
    localparam int WORD_W = 8 * WORD_BYTES;
    localparam int MEM_AW = ADDR_W - OFF_W;

    dc_state_t             state;
    logic [ADDR_W-1:0]     req_addr;
    logic                  req_we;
    logic [WORD_W-1:0]     req_wdata;
    logic [WORD_BYTES-1:0] req_be;
    logic                  touch_en, rd_load, st_en, fill_en;
    logic [1:0]            hit_vec;
    logic                  any_hit, hit_way, vic_way, vic_dirty;
    logic [TAG_W-1:0]      vic_tag;
    logic [1:0][LINE_W-1:0] rd_lines;
    logic                  way_q;
    logic [WORD_W-1:0]     rdata_q;

    wire [IDX_W-1:0]  req_idx  = req_addr[OFF_W +: IDX_W];
    wire [TAG_W-1:0]  req_tag  = req_addr[ADDR_W-1 -: TAG_W];
    wire [WSEL_W-1:0] req_wsel = req_addr[BYTE_W +: WSEL_W];

    assign any_hit = |hit_vec;
    assign hit_way = hit_vec[1];

    dcache2w_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_be    (cpu_be),
        .any_hit   (any_hit),
        .vic_dirty (vic_dirty),
        .mem_ack   (mem_ack),
        .state     (state),
        .req_addr  (req_addr),
        .req_we    (req_we),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .touch_en  (touch_en),
        .rd_load   (rd_load),
        .st_en     (st_en),
        .fill_en   (fill_en),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .cpu_ready (cpu_ready)
    );

    dcache2w_tags #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (req_idx),
        .tag       (req_tag),
        .hit_vec   (hit_vec),
        .vic_way   (vic_way),
        .vic_dirty (vic_dirty),
        .vic_tag   (vic_tag),
        .touch_en  (touch_en),
        .touch_way (hit_way),
        .fill_en   (fill_en),
        .dirty_en  (st_en),
        .dirty_way (way_q)
    );

    dcache2w_data #(
        .SETS(SETS), .IDX_W(IDX_W), .LINE_W(LINE_W), .WORD_W(WORD_W), .WSEL_W(WSEL_W)
    ) u_data (
        .clk       (clk),
        .idx       (req_idx),
        .rd_lines  (rd_lines),
        .fill_en   (fill_en),
        .fill_way  (vic_way),
        .fill_line (mem_rdata),
        .st_en     (st_en),
        .st_way    (way_q),
        .st_wsel   (req_wsel),
        .st_word   (req_wdata),
        .st_be     (req_be)
    );

    // Hit way and load word are captured in COMPARE; a miss leaves them alone.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            way_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (touch_en)
                way_q <= hit_way;
            if (rd_load)
                rdata_q <= rd_lines[hit_way][int'(req_wsel) * WORD_W +: WORD_W];
        end
    end

    assign cpu_rdata = rdata_q;
    assign mem_addr  = (state == ST_WRITEBACK) ? MEM_AW'({vic_tag, req_idx})
                                               : req_addr[ADDR_W-1:OFF_W];
    assign mem_wdata = rd_lines[vic_way];

endmodule

// File: rtl/dcache2w_chk.sv
module dcache2w_chk #(
    parameter int MEM_AW = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [MEM_AW-1:0] mem_addr
);

    AST_READY_LOW_IN_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready); // R9

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9

    AST_WB_THEN_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we)); // R8

    AST_REFILL_RECHECK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (!mem_req && !cpu_ready)); // R6

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready); // R3

endmodule

bind dcache2w dcache2w_chk #(.MEM_AW(MEM_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr)
);

// File: tb/tb_dcache2w.sv
module tb_dcache2w;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 12;
    localparam int LB   = 16;
    localparam int NS   = 4;
    localparam int WB   = 4;
    localparam int LW   = 8 * LB;
    localparam int MAW  = AW - 4;
    localparam int NLN  = 1 << MAW;
    localparam int LAT  = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cpu_req = 1'b0;
    logic           cpu_we = 1'b0;
    logic [AW-1:0]  cpu_addr = '0;
    logic [31:0]    cpu_wdata = '0;
    logic [3:0]     cpu_be = '0;
    logic [31:0]    cpu_rdata;
    logic           cpu_ready;
    logic           mem_req, mem_we;
    logic [MAW-1:0] mem_addr;
    logic [LW-1:0]  mem_wdata;
    logic [LW-1:0]  mem_rdata = '0;
    logic           mem_ack = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dcache2w #(.ADDR_W(AW), .LINE_BYTES(LB), .SETS(NS), .WORD_BYTES(WB)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic           we;
        logic [MAW-1:0] a;
        logic [LW-1:0]  d;
    } xfer_t;

    xfer_t          expq[$];
    logic [LW-1:0]  bmem [NLN];   // memory seen by the responder
    logic [LW-1:0]  rmem [NLN];   // memory as the model expects it
    logic           mv [NS][2];
    logic           md [NS][2];
    int             mt [NS][2];
    logic [LW-1:0]  mdat [NS][2];
    int             mlru [NS];

    task automatic chk(input bit ok, input string rq, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] seed_line(input int l);
        logic [LW-1:0] r;
        for (int w = 0; w < 4; w++)
            r[w * 32 +: 32] = 32'hC0DE0000 ^ (32'(l) << 4) ^ 32'(w) ^ (32'(l) * 32'h01010000);
        return r;
    endfunction

    // Memory responder: acknowledges each transfer after LAT cycles of request.
    int rcnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            rcnt = 0;
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            rcnt++;
            if (rcnt == LAT) begin
                rcnt = 0;
                mem_ack <= 1'b1;
                if (expq.size() == 0) begin
                    chk(1'b0, "R4/R8 unexpected memory transfer", {mem_we, mem_addr}, '0);
                end else begin
                    xfer_t e;
                    e = expq.pop_front();
                    chk(mem_we == e.we, "R4/R8 transfer direction", mem_we, e.we);
                    chk(mem_addr == e.a, "R2/R8 transfer line address", mem_addr, e.a);
                    if (e.we)
                        chk(mem_wdata == e.d, "R8 write-back contents", mem_wdata, e.d);
                end
                if (mem_we) bmem[mem_addr] = mem_wdata;
                else        mem_rdata <= bmem[mem_addr];
            end else begin
                mem_ack <= 1'b0;
            end
        end else begin
            rcnt = 0;
            mem_ack <= 1'b0;
        end
    end

    // One access: the model predicts latency, transfers and data; the bench
    // compares ready on every clock until the response.
    task automatic access(input logic we, input logic [AW-1:0] a, input logic [31:0] wd,
                          input logic [3:0] be, input string rq);
        int set, tg, ws, ln, h, v, lat;
        logic [31:0] expd;
        bit seen;
        set = int'(a[5:4]);
        tg  = int'(a[11:6]);
        ws  = int'(a[3:2]);
        ln  = int'(a[11:4]);
        h   = -1;
        for (int w = 0; w < 2; w++)
            if (mv[set][w] && mt[set][w] == tg) h = w;
        lat = 2;
        if (h < 0) begin
            v   = mlru[set];
            lat = 3 + LAT;
            if (mv[set][v] && md[set][v]) begin
                expq.push_back('{we: 1'b1, a: MAW'((mt[set][v] << 2) | set), d: mdat[set][v]});
                rmem[(mt[set][v] << 2) | set] = mdat[set][v];
                lat += LAT;
            end
            expq.push_back('{we: 1'b0, a: MAW'(ln), d: '0});
            mdat[set][v] = rmem[ln];
            mv[set][v]   = 1'b1;
            md[set][v]   = 1'b0;
            mt[set][v]   = tg;
            h = v;
        end
        mlru[set] = 1 - h;
        expd = mdat[set][h][ws * 32 +: 32];
        if (we) begin
            for (int b = 0; b < 4; b++)
                if (be[b]) mdat[set][h][ws * 32 + b * 8 +: 8] = wd[b * 8 +: 8];
            md[set][h] = 1'b1;
        end
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = a;
        cpu_wdata = wd;
        cpu_be    = be;
        seen = 1'b0;
        for (int c = 1; c <= lat + 40 && !seen; c++) begin
            @(negedge clk);
            chk(cpu_ready == (c == lat), {rq, " R9 ready cycle"}, cpu_ready, (c == lat));
            if (cpu_ready) seen = 1'b1;
        end
        if (!we)
            chk(cpu_rdata == expd, {rq, " load data"}, cpu_rdata, expd);
        cpu_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        for (int l = 0; l < NLN; l++) begin
            bmem[l] = seed_line(l);
            rmem[l] = seed_line(l);
        end
        for (int s = 0; s < NS; s++) begin
            mlru[s] = 0;
            for (int w = 0; w < 2; w++) begin
                mv[s][w] = 1'b0; md[s][w] = 1'b0; mt[s][w] = 0; mdat[s][w] = '0;
            end
        end
        repeat (3) @(negedge clk);
        chk(cpu_ready == 1'b0, "R1 ready low in reset", cpu_ready, 0);
        chk(mem_req == 1'b0, "R1 no memory request in reset", mem_req, 0);
        rst_n = 1'b1;
        @(negedge clk);

        access(0, 12'h000, 0, 0, "R1 R4 first load misses");
        access(0, 12'h004, 0, 0, "R3 R10 load hit word 1");
        access(0, 12'h00B, 0, 0, "R10 low bits ignored word 2");
        access(1, 12'h008, 32'hAABBCCDD, 4'b0101, "R5 store hit partial bytes");
        access(0, 12'h008, 0, 0, "R5 merged word read back");
        access(0, 12'h010, 0, 0, "R2 other set refill");
        access(0, 12'h100, 0, 0, "R7 second way filled");
        access(0, 12'h004, 0, 0, "R7 touch way 0");
        access(0, 12'h200, 0, 0, "R7 LRU evicts clean way 1");
        access(0, 12'h300, 0, 0, "R8 dirty victim written back");
        access(0, 12'h008, 0, 0, "R8 written data returns on refill");
        access(0, 12'h014, 0, 0, "R2 set 1 untouched by set 0 traffic");
        access(1, 12'h4A4, 32'h12345678, 4'b1111, "R6 store miss allocates");
        access(0, 12'h4A4, 0, 0, "R6 allocated store read back");
        access(1, 12'h4AC, 32'hFFEE0011, 4'b1000, "R5 single byte store");
        access(0, 12'h4AC, 0, 0, "R5 single byte merged");

        lf = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            logic [AW-1:0] a;
            logic [3:0]    be;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            a  = {4'b0, lf[1:0], lf[3:2], lf[5:4], lf[7:6]};
            be = lf[11:8];
            if (be == 4'b0) be = 4'b0010;
            access(lf[12], a, {lf, ~lf}, be, "R7 R8 mixed traffic");
        end

        chk(expq.size() == 0, "R4/R8 all predicted transfers seen", expq.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule